// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Step Steering

This block keeps a free-running time of day in the clock domain of a dedicated timestamp clock. The time is held as three fields: 48 bits of seconds, 30 bits of nanoseconds and 24 bits of binary fractions of a nanosecond. Every cycle the counter advances by a programmable increment. The increment holds 8 bits of nanoseconds and 24 bits of fraction, so a clock whose period is not a whole number of nanoseconds can be followed exactly. When the nanosecond part reaches one second, one second is subtracted and the seconds field counts up. The remainder is kept, so no time is lost across the boundary.

A 2-bit steering input can change any single cycle's step. It can make the step one nanosecond longer, make it one nanosecond shorter, or force a seconds step. A servo loop uses this to slew the clock without rewriting the increment. A build-time parameter selects a second meaning for the force code: the counter steps normally, and the current time is copied once into a capture register. The capture is re-armed only by the normal-step code.

The block drives the upper 94 bits of the time on a bus, and a once-per-second pulse derived from that bus. It also drives a registered flag that is high while the upper 70 bits of the time equal a programmed value. Three synchronous write strobes load the increment, the compare value and the time itself.

Top module: `tod_clock`

## Requirements
- R1: While reset is high and after its release, the time reads zero, the increment is 4 ns with zero fraction, the compare value is all ones, `cmp_match` is 0 and `pps_out` is 1.
- R2: With `step_ctl` = 2'b11 the time advances each cycle by the increment {ns, fraction}. A carry out of the 24-bit fraction adds to the nanoseconds.
- R3: With `step_ctl` = 2'b01 the step is the increment plus exactly 1 ns.
- R4: With `step_ctl` = 2'b10 the step is the increment minus 1 ns. If that would take the sub-second value below zero, the nanosecond and fraction fields become zero instead.
- R5: When a step reaches or passes 10^9 ns, 10^9 ns is subtracted, the remainder is kept and the seconds count up by one. The nanosecond field never reads 10^9 or more.
- R6: With the default build (`ALT_SNAP` = 0), `step_ctl` = 2'b00 zeroes the nanosecond and fraction fields and adds one second on every such cycle.
- R7: With `ALT_SNAP` = 1, `step_ctl` = 2'b00 steps normally. On the first such cycle after a 2'b11 cycle (or after reset) it copies the pre-step `timer_out` into `snap_out`. Further 2'b00 cycles leave `snap_out` unchanged until 2'b11 has been seen again.
- R8: `timer_out` is {seconds[47:0], ns[29:0], fraction[23:8]}, so bit 46 is the seconds LSB and toggles once per second.
- R9: `pps_out` is the inverse of `timer_out[45]` (ns bit 29). It is high for the first 2^29 ns of each second.
- R10: `cmp_match` is registered. It is high in the cycle after one in which `timer_out[93:24]` ({seconds, ns[29:8]}) equals the compare value.
- R11: `tod_wr` loads seconds and nanoseconds and clears the fraction at the next edge. The load takes priority over any step code.
- R12: `inc_wr` loads the increment at an edge. The step taken at that edge uses the old increment, and later steps use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst | input | 1 | Synchronous active-high reset |
| step_ctl | input | 2 | Per-cycle step steering: 11 normal, 01 long, 10 short, 00 force/capture |
| inc_wr | input | 1 | Load strobe for the increment |
| inc_ns_in | input | 8 | Increment nanoseconds |
| inc_sub_in | input | 24 | Increment fraction of a nanosecond |
| cmp_wr | input | 1 | Load strobe for the compare value |
| cmp_val | input | 70 | Compare value for {seconds, ns[29:8]} |
| tod_wr | input | 1 | Load strobe for the time |
| tod_sec | input | 48 | Seconds to load |
| tod_ns | input | 30 | Nanoseconds to load, below 10^9 |
| timer_out | output | 94 | Upper 94 bits of the time |
| pps_out | output | 1 | Once-per-second output |
| cmp_match | output | 1 | Registered compare-match flag |
| snap_out | output | 94 | Captured time (zero in the default build) |

## Verification
A step code or a write applied before an edge shows on `timer_out`, `pps_out` and `snap_out` right after that edge. `cmp_match` lags the time it describes by one further edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads exactly one rising edge of effect. For the compare flag, the bench counts steps to the cycle in which the time enters the matching window, checks that the flag is still low there, and checks that it is high one edge later. The window exit is checked the same way. A second instance built with the capture variant receives the same stimulus, and its capture register is checked for arming, holding and re-arming.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W    = 48;
    localparam int NS_W     = 30;
    localparam int SUB_W    = 24;
    localparam int FRAC_W   = NS_W + SUB_W;
    localparam int TIME_W   = SEC_W + FRAC_W;
    localparam int OUT_W    = 94;
    localparam int CMP_W    = 70;
    localparam int INC_NS_W = 8;
    localparam int INC_W    = INC_NS_W + SUB_W;
    localparam int PPS_BIT  = OUT_W - SEC_W - 1;

    typedef enum logic [1:0] {
        STEP_CLEAR = 2'b00,
        STEP_LONG  = 2'b01,
        STEP_SHORT = 2'b10,
        STEP_NORM  = 2'b11
    } step_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [SUB_W-1:0] sub;
    } tod_t;

    function automatic logic [OUT_W-1:0] tod_view(input tod_t t);
        return t[TIME_W-1 -: OUT_W];
    endfunction

    function automatic logic [CMP_W-1:0] tod_hi(input tod_t t);
        return t[TIME_W-1 -: CMP_W];
    endfunction
endpackage

// File: rtl/tod_step.sv
module tod_step
    import tod_pkg::*;
#(
    parameter bit              ALT_SNAP   = 1'b0,
    parameter longint unsigned NS_PER_SEC = 64'd1_000_000_000
) (
    input  tod_t                cur,
    input  logic [1:0]          ctl,
    input  logic [INC_NS_W-1:0] inc_ns,
    input  logic [SUB_W-1:0]    inc_sub,
    output tod_t                nxt
);
    localparam int ACC_W = FRAC_W + 1;
    localparam logic [ACC_W-1:0] ONE_NS  = ACC_W'(1) << SUB_W;
    localparam logic [ACC_W-1:0] ONE_SEC = ACC_W'(NS_PER_SEC) << SUB_W;

    logic [ACC_W-1:0]  raw;
    logic [ACC_W-1:0]  adj;
    logic [FRAC_W-1:0] rem;
    logic              force_sec;
    logic              wrap;

    always_comb begin
        raw       = {1'b0, cur.ns, cur.sub} + ACC_W'({inc_ns, inc_sub});
        adj       = raw;
        force_sec = 1'b0;
        case (step_e'(ctl))
            STEP_LONG:  adj = raw + ONE_NS;
            STEP_SHORT: adj = (raw < ONE_NS) ? '0 : raw - ONE_NS;
            STEP_CLEAR: force_sec = !ALT_SNAP;
            default:    adj = raw;
        endcase
        wrap    = (adj >= ONE_SEC);
        rem     = FRAC_W'(wrap ? adj - ONE_SEC : adj);
        nxt.sec = cur.sec + SEC_W'(force_sec || wrap);
        nxt.ns  = force_sec ? '0 : rem[SUB_W +: NS_W];
        nxt.sub = force_sec ? '0 : rem[SUB_W-1:0];
    end
endmodule

// File: rtl/tod_snap.sv
module tod_snap
    import tod_pkg::*;
#(
    parameter int W = OUT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   ctl,
    input  logic [W-1:0] cur,
    output logic [W-1:0] snap
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            snap  <= '0;
        end else if (ctl == STEP_NORM) begin
            armed <= 1'b1;
        end else if (ctl == STEP_CLEAR && armed) begin
            armed <= 1'b0;
            snap  <= cur;
        end
    end
endmodule

// File: rtl/tod_cmp.sv
module tod_cmp #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] val,
    input  logic [W-1:0] time_hi,
    output logic [W-1:0] cmp_q,
    output logic         match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            match <= 1'b0;
        end else begin
            if (wr) cmp_q <= val;
            match <= (time_hi == cmp_q);
        end
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter bit                    ALT_SNAP    = 1'b0,
    parameter longint unsigned       NS_PER_SEC  = 64'd1_000_000_000,
    parameter logic [INC_NS_W-1:0]   RST_INC_NS  = 8'd4,
    parameter logic [SUB_W-1:0]      RST_INC_SUB = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          step_ctl,
    input  logic                inc_wr,
    input  logic [INC_NS_W-1:0] inc_ns_in,
    input  logic [SUB_W-1:0]    inc_sub_in,
    input  logic                cmp_wr,
    input  logic [CMP_W-1:0]    cmp_val,
    input  logic                tod_wr,
    input  logic [SEC_W-1:0]    tod_sec,
    input  logic [NS_W-1:0]     tod_ns,
    output logic [OUT_W-1:0]    timer_out,
    output logic                pps_out,
    output logic                cmp_match,
    output logic [OUT_W-1:0]    snap_out
);
    tod_t                tod_q;
    tod_t                tod_nxt;
    logic [INC_NS_W-1:0] inc_ns_q;
    logic [SUB_W-1:0]    inc_sub_q;
    logic [CMP_W-1:0]    cmp_q;

    tod_step #(.ALT_SNAP(ALT_SNAP), .NS_PER_SEC(NS_PER_SEC)) u_step (
        .cur(tod_q), .ctl(step_ctl), .inc_ns(inc_ns_q), .inc_sub(inc_sub_q), .nxt(tod_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q     <= '0;
            inc_ns_q  <= RST_INC_NS;
            inc_sub_q <= RST_INC_SUB;
        end else begin
            if (inc_wr) begin
                inc_ns_q  <= inc_ns_in;
                inc_sub_q <= inc_sub_in;
            end
            if (tod_wr) begin
                tod_q.sec <= tod_sec;
                tod_q.ns  <= tod_ns;
                tod_q.sub <= '0;
            end else begin
                tod_q <= tod_nxt;
            end
        end
    end

    assign timer_out = tod_view(tod_q);
    assign pps_out   = ~timer_out[PPS_BIT];

    tod_cmp #(.W(CMP_W)) u_cmp (
        .clk(clk), .rst(rst), .wr(cmp_wr), .val(cmp_val),
        .time_hi(tod_hi(tod_q)), .cmp_q(cmp_q), .match(cmp_match)
    );

    generate
        if (ALT_SNAP) begin : g_snap
            tod_snap #(.W(OUT_W)) u_snap (
                .clk(clk), .rst(rst), .ctl(step_ctl), .cur(timer_out), .snap(snap_out)
            );
        end else begin : g_nosnap
            assign snap_out = '0;
        end
    endgenerate
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter bit              ALT_SNAP   = 1'b0,
    parameter longint unsigned NS_PER_SEC = 64'd1_000_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       step_ctl,
    input logic             tod_wr,
    input logic [SEC_W-1:0] tod_sec,
    input logic [NS_W-1:0]  tod_ns,
    input logic [OUT_W-1:0] timer_out,
    input logic [CMP_W-1:0] cmp_q,
    input logic             cmp_match,
    input logic [OUT_W-1:0] snap_out
);
    // R5
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        64'(timer_out[OUT_W-SEC_W-1 -: NS_W]) < NS_PER_SEC);

    // R11
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        tod_wr |=> (timer_out[OUT_W-1:OUT_W-SEC_W-NS_W] == {$past(tod_sec), $past(tod_ns)})
                   && (timer_out[OUT_W-SEC_W-NS_W-1:0] == '0));

    // R2
    sec_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !tod_wr |=> timer_out[OUT_W-1 -: SEC_W] >= $past(timer_out[OUT_W-1 -: SEC_W]));

    // R10
    cmp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cmp_match == $past(timer_out[OUT_W-1 -: CMP_W] == cmp_q));

    generate
        if (ALT_SNAP) begin : g_alt
            // R7
            snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (step_ctl != 2'b00) |=> $stable(snap_out));
        end else begin : g_def
            // R6
            clear_step_chk: assert property (@(posedge clk) disable iff (rst)
                (!tod_wr && step_ctl == 2'b00) |=>
                    (timer_out[OUT_W-SEC_W-1:0] == '0) &&
                    (timer_out[OUT_W-1 -: SEC_W] == SEC_W'($past(timer_out[OUT_W-1 -: SEC_W]) + 1)));
        end
    endgenerate
endmodule

bind tod_clock tod_clock_chk #(.ALT_SNAP(ALT_SNAP), .NS_PER_SEC(NS_PER_SEC)) u_chk (
    .clk(clk), .rst(rst), .step_ctl(step_ctl), .tod_wr(tod_wr), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .timer_out(timer_out), .cmp_q(cmp_q), .cmp_match(cmp_match),
    .snap_out(snap_out)
);

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  step_ctl = 2'b11;
    logic        inc_wr = 1'b0;
    logic [7:0]  inc_ns_in = '0;
    logic [23:0] inc_sub_in = '0;
    logic        cmp_wr = 1'b0;
    logic [69:0] cmp_val = '0;
    logic        tod_wr = 1'b0;
    logic [47:0] tod_sec = '0;
    logic [29:0] tod_ns = '0;
    logic [93:0] timer_out, alt_timer, snap_out, alt_snap;
    logic        pps_out, cmp_match, alt_pps, alt_cmp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tod_clock u_tod_clock (
        .clk(clk), .rst(rst), .step_ctl(step_ctl), .inc_wr(inc_wr), .inc_ns_in(inc_ns_in),
        .inc_sub_in(inc_sub_in), .cmp_wr(cmp_wr), .cmp_val(cmp_val), .tod_wr(tod_wr),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .timer_out(timer_out), .pps_out(pps_out),
        .cmp_match(cmp_match), .snap_out(snap_out)
    );

    tod_clock #(.ALT_SNAP(1'b1)) u_alt (
        .clk(clk), .rst(rst), .step_ctl(step_ctl), .inc_wr(inc_wr), .inc_ns_in(inc_ns_in),
        .inc_sub_in(inc_sub_in), .cmp_wr(cmp_wr), .cmp_val(cmp_val), .tod_wr(tod_wr),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .timer_out(alt_timer), .pps_out(alt_pps),
        .cmp_match(alt_cmp), .snap_out(alt_snap)
    );

    function automatic logic [93:0] mk(input logic [47:0] s, input logic [29:0] n,
                                       input logic [23:0] f);
        return {s, n, f[23:8]};
    endfunction

    task automatic chk(input string req, input logic [93:0] act, input logic [93:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [47:0] s, input logic [29:0] n);
        tod_wr = 1'b1; tod_sec = s; tod_ns = n; step_ctl = 2'b11;
        step();
        tod_wr = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  ctl;
        logic [7:0]  ins;
        logic [23:0] isub;
        logic [29:0] ns0;
        logic [47:0] s_exp;
        logic [29:0] ns_exp;
        logic [23:0] sub_exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b11, 8'd4, 24'h0,      30'd100,       48'd5, 30'd104, 24'h0},      // R2
        '{2'b11, 8'd3, 24'h800000, 30'd100,       48'd5, 30'd103, 24'h800000}, // R2
        '{2'b01, 8'd4, 24'h0,      30'd100,       48'd5, 30'd105, 24'h0},      // R3
        '{2'b10, 8'd4, 24'h0,      30'd100,       48'd5, 30'd103, 24'h0},      // R4
        '{2'b10, 8'd0, 24'h400000, 30'd0,         48'd5, 30'd0,   24'h0},      // R4 floor
        '{2'b11, 8'd4, 24'h0,      30'd999999998, 48'd6, 30'd2,   24'h0},      // R5
        '{2'b01, 8'd4, 24'h0,      30'd999999996, 48'd6, 30'd1,   24'h0},      // R5 with R3
        '{2'b00, 8'd4, 24'h0,      30'd12345,     48'd6, 30'd0,   24'h0}       // R6
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        // R1 reset state
        chk("R1 time", timer_out, '0);
        chk("R1 pps", 94'(pps_out), 94'(1));
        chk("R1 cmp", 94'(cmp_match), 94'(0));
        rst = 1'b0;
        step();
        chk("R1 reset increment", timer_out, mk(0, 4, 0));
        // R12 new increment applies after the write edge
        inc_wr = 1'b1; inc_ns_in = 8'd10; inc_sub_in = '0;
        step();
        inc_wr = 1'b0;
        chk("R12 old inc at write edge", timer_out, mk(0, 8, 0));
        step();
        chk("R12 new inc", timer_out, mk(0, 18, 0));

        foreach (VECS[i]) begin
            inc_wr = 1'b1; inc_ns_in = VECS[i].ins; inc_sub_in = VECS[i].isub;
            load(48'd5, VECS[i].ns0);
            inc_wr = 1'b0;
            step_ctl = VECS[i].ctl;
            step();
            chk($sformatf("table vector %0d (R2..R6)", i), timer_out,
                mk(VECS[i].s_exp, VECS[i].ns_exp, VECS[i].sub_exp));
            step_ctl = 2'b11;
        end

        // R8 and R9: output mapping and pulse per second
        load(48'd1, 30'd536870911);
        chk("R8 mapping", timer_out, mk(1, 536870911, 0));
        chk("R8 seconds lsb", 94'(timer_out[46]), 94'(1));
        chk("R9 pps high", 94'(pps_out), 94'(1));
        step();
        chk("R9 pps low", 94'(pps_out), 94'(0));

        // R11 load wins over force code
        tod_wr = 1'b1; tod_sec = 48'd7; tod_ns = 30'd50; step_ctl = 2'b00;
        step();
        tod_wr = 1'b0;
        chk("R11 load priority", timer_out, mk(7, 50, 0));

        // R6 repeated force steps
        step_ctl = 2'b11;
        load(48'd2, 30'd777);
        step_ctl = 2'b00;
        step();
        chk("R6 first force", timer_out, mk(3, 0, 0));
        step();
        chk("R6 second force", timer_out, mk(4, 0, 0));

        // R7 capture variant
        load(48'd3, 30'd0);
        step_ctl = 2'b00;
        step();
        chk("R7 capture", alt_snap, mk(3, 0, 0));
        chk("R7 normal step", alt_timer, mk(3, 4, 0));
        step();
        chk("R7 no recapture", alt_snap, mk(3, 0, 0));
        step_ctl = 2'b11;
        step();
        step_ctl = 2'b00;
        step();
        chk("R7 rearmed capture", alt_snap, mk(3, 12, 0));
        chk("R7 timer", alt_timer, mk(3, 16, 0));

        // R10 compare window {sec 9, ns 256..511}
        step_ctl = 2'b11;
        cmp_wr = 1'b1; cmp_val = {48'd9, 22'd1};
        load(48'd9, 30'd200);
        cmp_wr = 1'b0;
        repeat (14) step();
        chk("R10 entry time", timer_out, mk(9, 256, 0));
        chk("R10 lag low", 94'(cmp_match), 94'(0));
        step();
        chk("R10 match high", 94'(cmp_match), 94'(1));
        repeat (63) step();
        chk("R10 exit time", timer_out, mk(9, 512, 0));
        chk("R10 still high", 94'(cmp_match), 94'(1));
        step();
        chk("R10 match low", 94'(cmp_match), 94'(0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule